// File: doc/BRIEF.md
# Auto-Restart and Shutdown Supervisor

This block sequences the supply of a switching regulator's controller. It takes digitized comparator flags for the controller supply rail and two fault flags. It drives an enable for the start-up bias current source and an enable for the PWM switching stage. After the first charge of the rail, switching starts. If the rail later sags to its lower threshold while switching, the block falls into a hysteretic restart mode. In that mode the bias source recharges the rail and a modulo-8 counter lets switching resume only on every eighth charge, which keeps dissipation low during a persistent overload.

A trip request or an over-temperature flag forces a latched-off state. In this state the rail is still held in its hysteresis window by the bias source, and switching never resumes. Only the rail falling below its power-up-reset level clears the latch, the counter and all other state. The comparators, the shunt regulator and all capacitance-dependent timing are outside the block.

Top module: `restart_supervisor`

## Requirements
- R1: After reset the state code is 0 (initial charge), bias_en_o is 1, sw_en_o is 0 and cnt_o is 0.
- R2: Every input passes through a SYNC_STAGES-flop synchronizer. An input change made between two clock edges shows on the outputs after the SYNC_STAGES+1-th following rising edge (3 by default) and not earlier.
- R3: In the initial charge state (code 0), a rising edge of rail_hi_i moves the block to run (code 1), with sw_en_o=1 and bias_en_o=0. In run, rail_hi_i has no effect, and sw_en_o and bias_en_o are never both 1.
- R4: In run, a rising edge of rail_lo_i moves the block to restart-charge (code 2) with cnt_o cleared to 0, bias_en_o=1 and sw_en_o=0.
- R5: In restart-charge, a rising edge of rail_hi_i with cnt_o below 7 moves to restart-discharge (code 3), where both enables are 0. In restart-discharge, a rising edge of rail_lo_i returns to restart-charge with cnt_o incremented by one.
- R6: In restart-charge with cnt_o equal to 7, a rising edge of rail_hi_i returns to run and clears cnt_o. Switching is therefore enabled during one of every eight rail discharge cycles.
- R7: Each low-threshold crossing is counted once: holding rail_lo_i high over many cycles advances cnt_o by at most one.
- R8: When trip_i or hot_i is high and rail_por_i is low, the block enters latched-off (code 4) from any state, with sw_en_o=0 and bias_en_o=0 on entry.
- R9: In latched-off, sw_en_o stays 0. bias_en_o becomes 1 while rail_lo_i is high, becomes 0 while rail_hi_i is high (rail_lo_i wins if both are high), and otherwise holds. Neither threshold flag nor the removal of the fault leaves the state.
- R10: rail_por_i high returns the block to code 0 with cnt_o=0, whatever the state and whatever the fault flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rail_hi_i | input | 1 | Rail at or above upper threshold |
| rail_lo_i | input | 1 | Rail at or below lower threshold |
| rail_por_i | input | 1 | Rail below power-up-reset level |
| trip_i | input | 1 | Latching shutdown request |
| hot_i | input | 1 | Over-temperature flag |
| bias_en_o | output | 1 | Start-up bias source enable |
| sw_en_o | output | 1 | PWM switching enable |
| state_o | output | 3 | State code: 0 charge, 1 run, 2 restart-charge, 3 restart-discharge, 4 latched-off |
| cnt_o | output | 3 | Restart cycle counter |

## Verification
Every result is due on the third rising edge after an input change: two synchronizer flops, then the state register. The bias output in the latched state follows the same path. The bench drives each input on a falling edge, waits three rising edges and samples on the next falling edge. It also makes one check after only two edges to confirm that nothing moves early. Each stimulus is held for at least three cycles, so one rising edge of a threshold flag yields exactly one event.

// File: rtl/sup_pkg.sv
package sup_pkg;
  localparam int ST_W = 3;
  typedef enum logic [ST_W-1:0] {
    ST_CHARGE = 3'd0,
    ST_RUN    = 3'd1,
    ST_AR_CHG = 3'd2,
    ST_AR_DIS = 3'd3,
    ST_LATCH  = 3'd4
  } sup_state_e;
endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else if (s == 0) stg_q[s] <= d_i;
      else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/sup_edge.sv
module sup_edge #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else prev_q <= d_i;
  end

  for (genvar i = 0; i < W; i++) begin : g_rise
    assign rise_o[i] = d_i[i] & ~prev_q[i];
  end
endmodule

// File: rtl/sup_ctrl.sv
module sup_ctrl
  import sup_pkg::*;
#(
  parameter int RESTART_DIV = 8,
  parameter int CNT_W       = $clog2(RESTART_DIV)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hi_s_i,
  input  logic             lo_s_i,
  input  logic             hi_rise_i,
  input  logic             lo_rise_i,
  input  logic             por_s_i,
  input  logic             fault_s_i,
  output logic [ST_W-1:0]  state_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             bias_en_o,
  output logic             sw_en_o
);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RESTART_DIV - 1);

  sup_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             lbias_q, lbias_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    lbias_d = lbias_q;
    if (por_s_i) begin
      state_d = ST_CHARGE;
      cnt_d   = '0;
      lbias_d = 1'b0;
    end else if (fault_s_i && state_q != ST_LATCH) begin
      state_d = ST_LATCH;
      lbias_d = 1'b0;
    end else begin
      unique case (state_q)
        ST_CHARGE: if (hi_rise_i) state_d = ST_RUN;
        ST_RUN: if (lo_rise_i) begin
          state_d = ST_AR_CHG;
          cnt_d   = '0;
        end
        ST_AR_CHG: if (hi_rise_i) begin
          if (cnt_q == CNT_LAST) begin
            state_d = ST_RUN;
            cnt_d   = '0;
          end else begin
            state_d = ST_AR_DIS;
          end
        end
        ST_AR_DIS: if (lo_rise_i) begin
          state_d = ST_AR_CHG;
          cnt_d   = cnt_q + 1'b1;
        end
        ST_LATCH: begin
          // level-based hysteresis: entry may occur with the rail already low
          if (lo_s_i) lbias_d = 1'b1;
          else if (hi_s_i) lbias_d = 1'b0;
        end
        default: state_d = ST_CHARGE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_CHARGE;
      cnt_q   <= '0;
      lbias_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      lbias_q <= lbias_d;
    end
  end

  always_comb begin
    unique case (state_q)
      ST_CHARGE, ST_AR_CHG: bias_en_o = 1'b1;
      ST_LATCH:             bias_en_o = lbias_q;
      default:              bias_en_o = 1'b0;
    endcase
  end

  assign sw_en_o = (state_q == ST_RUN);
  assign state_o = state_q;
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/restart_supervisor.sv
module restart_supervisor
  import sup_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RESTART_DIV = 8,
  parameter int CNT_W       = $clog2(RESTART_DIV)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rail_hi_i,
  input  logic             rail_lo_i,
  input  logic             rail_por_i,
  input  logic             trip_i,
  input  logic             hot_i,
  output logic             bias_en_o,
  output logic             sw_en_o,
  output logic [ST_W-1:0]  state_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam int N_IN = 5;

  logic [N_IN-1:0] raw, syn;
  logic [1:0]      rise;
  logic            hi_s, lo_s, por_s, fault_s;

  assign raw = {hot_i, trip_i, rail_por_i, rail_lo_i, rail_hi_i};

  sup_sync #(.W(N_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (syn)
  );

  assign hi_s    = syn[0];
  assign lo_s    = syn[1];
  assign por_s   = syn[2];
  assign fault_s = syn[3] | syn[4];

  sup_edge #(.W(2)) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({lo_s, hi_s}),
    .rise_o(rise)
  );

  sup_ctrl #(.RESTART_DIV(RESTART_DIV), .CNT_W(CNT_W)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hi_s_i   (hi_s),
    .lo_s_i   (lo_s),
    .hi_rise_i(rise[0]),
    .lo_rise_i(rise[1]),
    .por_s_i  (por_s),
    .fault_s_i(fault_s),
    .state_o  (state_o),
    .cnt_o    (cnt_o),
    .bias_en_o(bias_en_o),
    .sw_en_o  (sw_en_o)
  );
endmodule

// File: rtl/restart_supervisor_chk.sv
module restart_supervisor_chk
  import sup_pkg::*;
#(
  parameter int RESTART_DIV = 8,
  parameter int CNT_W       = $clog2(RESTART_DIV)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [ST_W-1:0]  state_o,
  input logic [CNT_W-1:0] cnt_o,
  input logic             bias_en_o,
  input logic             sw_en_o,
  input logic             por_s,
  input logic             fault_s,
  input logic [1:0]       rise
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RESTART_DIV - 1);

  p_run_no_bias_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_en_o |-> !bias_en_o);

  p_cnt_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_AR_DIS && rise[1] && !por_s && !fault_s)
      |=> cnt_o == $past(cnt_o) + 1'b1);

  p_run_entry_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sw_en_o) |-> ($past(state_o) == ST_CHARGE ||
                        ($past(state_o) == ST_AR_CHG && $past(cnt_o) == LAST)));

  p_cnt_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_AR_DIS && !rise[1] && !por_s) |=> $stable(cnt_o));

  p_fault_latch_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_s && !por_s) |=> (state_o == ST_LATCH && !sw_en_o));

  p_latch_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_LATCH && !por_s) |=> state_o == ST_LATCH);

  p_por_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_s |=> (state_o == ST_CHARGE && cnt_o == '0));
endmodule

bind restart_supervisor restart_supervisor_chk #(
  .RESTART_DIV(RESTART_DIV),
  .CNT_W      (CNT_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .state_o  (state_o),
  .cnt_o    (cnt_o),
  .bias_en_o(bias_en_o),
  .sw_en_o  (sw_en_o),
  .por_s    (por_s),
  .fault_s  (fault_s),
  .rise     (rise)
);

// File: tb/restart_supervisor_bench.sv
`timescale 1ns/1ps
module restart_supervisor_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hi = 1'b0, lo = 1'b0, por = 1'b0, trip = 1'b0, hot = 1'b0;
  logic       bias_en, sw_en;
  logic [2:0] state, cnt;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  restart_supervisor u_restart_supervisor (
    .clk_i(clk), .rst_ni(rst_n),
    .rail_hi_i(hi), .rail_lo_i(lo), .rail_por_i(por),
    .trip_i(trip), .hot_i(hot),
    .bias_en_o(bias_en), .sw_en_o(sw_en),
    .state_o(state), .cnt_o(cnt)
  );

  // {trip, hot, por, hi, lo, exp_state, exp_bias, exp_sw, exp_cnt, req}
  localparam int NV = 13;
  localparam logic [16:0] VEC [NV] = '{
    {1'b0,1'b0,1'b0,1'b1,1'b0, 3'd1,1'b0,1'b1,3'd0, 4'd3}, // R3 hi held
    {1'b0,1'b0,1'b0,1'b0,1'b0, 3'd1,1'b0,1'b1,3'd0, 4'd3}, // R3
    {1'b0,1'b0,1'b0,1'b1,1'b0, 3'd1,1'b0,1'b1,3'd0, 4'd3}, // R3 hi rise ignored in run
    {1'b0,1'b0,1'b0,1'b0,1'b1, 3'd2,1'b1,1'b0,3'd0, 4'd4}, // R4
    {1'b0,1'b0,1'b0,1'b0,1'b1, 3'd2,1'b1,1'b0,3'd0, 4'd7}, // R7
    {1'b0,1'b0,1'b0,1'b0,1'b0, 3'd2,1'b1,1'b0,3'd0, 4'd7}, // R7
    {1'b0,1'b0,1'b0,1'b1,1'b0, 3'd3,1'b0,1'b0,3'd0, 4'd5}, // R5
    {1'b0,1'b0,1'b0,1'b0,1'b1, 3'd2,1'b1,1'b0,3'd1, 4'd5}, // R5
    {1'b0,1'b0,1'b0,1'b0,1'b0, 3'd2,1'b1,1'b0,3'd1, 4'd5}, // R5
    {1'b0,1'b0,1'b0,1'b1,1'b0, 3'd3,1'b0,1'b0,3'd1, 4'd5}, // R5
    {1'b0,1'b0,1'b0,1'b0,1'b1, 3'd2,1'b1,1'b0,3'd2, 4'd5}, // R5
    {1'b0,1'b0,1'b0,1'b0,1'b1, 3'd2,1'b1,1'b0,3'd2, 4'd7}, // R7 held low
    {1'b0,1'b0,1'b0,1'b0,1'b0, 3'd2,1'b1,1'b0,3'd2, 4'd7}  // R7
  };

  task automatic drive(input logic t, input logic h, input logic p,
                       input logic up, input logic dn);
    @(negedge clk);
    trip = t; hot = h; por = p; hi = up; lo = dn;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [2:0] es, input logic eb,
                       input logic ew, input logic [2:0] ec);
    checks++;
    if (state !== es || bias_en !== eb || sw_en !== ew || cnt !== ec) begin
      errors++;
      $display("FAIL %s: state=%0d bias=%0d sw=%0d cnt=%0d expected state=%0d bias=%0d sw=%0d cnt=%0d",
               req, state, bias_en, sw_en, cnt, es, eb, ew, ec);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 3'd0, 1'b1, 1'b0, 3'd0);

    // R2: output must not move before the third edge
    @(negedge clk);
    hi = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R2", 3'd0, 1'b1, 1'b0, 3'd0);
    @(posedge clk);
    @(negedge clk);
    check("R2", 3'd1, 1'b0, 1'b1, 3'd0);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][16], VEC[i][15], VEC[i][14], VEC[i][13], VEC[i][12]);
      check($sformatf("R%0d vec%0d", VEC[i][3:0], i),
            VEC[i][11:9], VEC[i][8], VEC[i][7], VEC[i][6:4]);
    end

    // R5: remaining restart cycles up to count 7
    for (int k = 2; k < 7; k++) begin
      drive(0, 0, 0, 1, 0);
      check("R5", 3'd3, 1'b0, 1'b0, 3'(k));
      drive(0, 0, 0, 0, 1);
      check("R5", 3'd2, 1'b1, 1'b0, 3'(k + 1));
      drive(0, 0, 0, 0, 0);
    end
    drive(0, 0, 0, 1, 0);
    check("R6", 3'd1, 1'b0, 1'b1, 3'd0);
    drive(0, 0, 0, 0, 0);
    check("R6", 3'd1, 1'b0, 1'b1, 3'd0);

    // R8 / R9 latched-off
    drive(1, 0, 0, 0, 0);
    check("R8", 3'd4, 1'b0, 1'b0, 3'd0);
    drive(0, 0, 0, 0, 0);
    check("R9", 3'd4, 1'b0, 1'b0, 3'd0);
    drive(0, 0, 0, 0, 1);
    check("R9", 3'd4, 1'b1, 1'b0, 3'd0);
    drive(0, 0, 0, 0, 0);
    check("R9", 3'd4, 1'b1, 1'b0, 3'd0);
    drive(0, 0, 0, 1, 0);
    check("R9", 3'd4, 1'b0, 1'b0, 3'd0);
    drive(0, 0, 0, 0, 0);
    check("R9", 3'd4, 1'b0, 1'b0, 3'd0);

    // R10: power-up reset wins over an active fault
    drive(1, 0, 1, 0, 0);
    check("R10", 3'd0, 1'b1, 1'b0, 3'd0);
    drive(0, 0, 0, 0, 0);
    check("R10", 3'd0, 1'b1, 1'b0, 3'd0);
    drive(0, 1, 0, 0, 0);
    check("R8", 3'd4, 1'b0, 1'b0, 3'd0);
    drive(0, 0, 1, 0, 0);
    check("R10", 3'd0, 1'b1, 1'b0, 3'd0);
    drive(0, 0, 0, 0, 0);

    // R10: power-up reset in the middle of a restart sequence
    drive(0, 0, 0, 1, 0);
    check("R3", 3'd1, 1'b0, 1'b1, 3'd0);
    drive(0, 0, 0, 0, 1);
    check("R4", 3'd2, 1'b1, 1'b0, 3'd0);
    drive(0, 0, 0, 1, 0);
    drive(0, 0, 0, 0, 1);
    check("R5", 3'd2, 1'b1, 1'b0, 3'd1);
    drive(0, 0, 0, 0, 0);
    drive(0, 0, 1, 0, 0);
    check("R10", 3'd0, 1'b1, 1'b0, 3'd0);
    drive(0, 0, 0, 0, 0);
    check("R10", 3'd0, 1'b1, 1'b0, 3'd0);

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule